// File: doc/BRIEF.md
# Capacitive Key Detection Channel Processor

This block is the digital decision stage for one key of a burst-mode capacitive touch sensor. Once per acquisition cycle the front end presents a 16-bit raw count with a one-clock `raw_valid` strobe. The block compares that count against a reference it learned during calibration. It filters the comparison through a three-sample consensus counter and drives one logical key output. A per-key pad stage then converts that output into either push-pull or open-drain form.

The reference follows slow environmental drift one count at a time, and only while no detection is held. It steps down faster than it steps up. A maximum on-time timer catches stuck keys and forces the channel to recalibrate. Two strap pins choose between a direct output and a touch-on/touch-off toggle output, and also pick the timeout length. The straps and the drive-type strap are captured on every valid sample, so they may change while the block runs. An external arbiter can hold off a confirmed detection through `arb_block`.

The controller is a five-state machine:
- `ST_CAL`: waiting for the next sample, which it loads as the reference.
- `ST_IDLE`: no candidate.
- `ST_FILTER`: counting consecutive candidates.
- `ST_SUPPR`: confirmed, but held off by the arbiter.
- `ST_DETECT`: detection held.

Its transitions are:
- reset to CAL.
- CAL to IDLE on any sample.
- IDLE to FILTER on a candidate.
- FILTER back to IDLE on a non-candidate.
- FILTER to DETECT on the third candidate, or to SUPPR if blocked.
- SUPPR to IDLE on a non-candidate, or to DETECT on a candidate once unblocked.
- DETECT to IDLE on release.
- DETECT to CAL on timer expiry.

Top module: `touch_key_proc`

## Requirements
- R1: After reset, or after any reset pulse during operation, `key_on` is 0. The first valid sample after reset loads the reference and never counts as a candidate.
- R2: A sample is a candidate when raw >= reference + 6. A sample at reference + 5 is not a candidate.
- R3: `key_on` becomes active at the clock edge of the 3rd consecutive candidate sample. Any non-candidate sample before that restarts the count. Outputs change only at edges where `raw_valid` is 1.
- R4: A held detection releases at the first sample with raw < reference + 4. A sample at reference + 4 keeps it held.
- R5: In IDLE or FILTER, every 30th consecutive sample above the reference raises the reference by exactly 1 (default 33 ms acquisition period).
- R6: In IDLE or FILTER, every 7th consecutive sample below the reference lowers it by exactly 1. Six such samples leave it unchanged.
- R7: The reference does not change while a detection is held, or while a key is held off by the arbiter.
- R8: While `arb_block` is 1, a confirmed key does not activate. When it drops, the next candidate sample activates the key at once. `arb_block` has no effect on a key that is already detected.
- R9: With the straps set to opt_a=1, opt_b=1 (direct, 10 s), `key_on` drops at the 303rd sample after confirmation. The channel then recalibrates from the next sample.
- R10: With opt_a=1, opt_b=0 (direct, 60 s), `key_on` drops at the 1818th sample after confirmation. With opt_a=0, opt_b=0 (direct, no timeout), it never drops while touched.
- R11: With opt_a=0, opt_b=1 (toggle), each newly confirmed touch inverts `key_on`. A release leaves it unchanged. The 10 s timeout (303 samples) recalibrates the channel but keeps `key_on` as it was.
- R12: The straps are captured at each valid sample and take effect from that edge. A strap change between samples has no effect at the ports.
- R13: With oc=0, `pad_oe`=1 and `pad_o`=`key_on` (active-high drive). With oc=1, `pad_o`=0 and `pad_oe`=`key_on` (active-low, open-drain).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces recalibration |
| raw_valid | input | 1 | One-clock strobe marking a new raw count |
| raw_count | input | 16 | Raw acquisition count for this key |
| strap_opt_a | input | 1 | Mode/timeout strap A |
| strap_opt_b | input | 1 | Mode/timeout strap B |
| strap_oc | input | 1 | Drive type strap: 0 push-pull, 1 open-drain |
| arb_block | input | 1 | Arbiter hold-off for this key |
| key_on | output | 1 | Logical key state |
| pad_o | output | 1 | Pad output level |
| pad_oe | output | 1 | Pad output enable |

## Verification
A wrong reference is invisible on its own. It shows up only as a shifted detection boundary: the key either fails to confirm at reference + 6, or confirms one count early or late. That error appears three samples after the next touch. A stuck integrator or state register shows up on the very sample edge where confirmation or release should occur. A timer that miscounts moves the output drop by exactly the error in samples, which the bench pins to a single sample on each side.

// File: rtl/tkp_pkg.sv
package tkp_pkg;

    typedef enum logic [2:0] {
        ST_CAL,
        ST_IDLE,
        ST_FILTER,
        ST_SUPPR,
        ST_DETECT
    } det_state_t;

    typedef enum logic [1:0] {
        MD_DIRECT_INF,
        MD_DIRECT_SHORT,
        MD_DIRECT_LONG,
        MD_TOGGLE
    } out_mode_t;

    // Strap pair {a,b}: 01 toggle, 11 direct short, 10 direct long, 00 direct no timeout
    function automatic out_mode_t decode_straps(input logic a, input logic b);
        out_mode_t m;
        unique case ({a, b})
            2'b01:   m = MD_TOGGLE;
            2'b11:   m = MD_DIRECT_SHORT;
            2'b10:   m = MD_DIRECT_LONG;
            default: m = MD_DIRECT_INF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tkp_strap_latch.sv
module tkp_strap_latch
    import tkp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sample,
    input  logic      opt_a,
    input  logic      opt_b,
    input  logic      oc_in,
    output out_mode_t mode_q,
    output logic      oc_q
);

    // Straps are captured only once per acquisition cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_DIRECT_INF;
            oc_q   <= 1'b0;
        end else if (sample) begin
            mode_q <= decode_straps(opt_a, opt_b);
            oc_q   <= oc_in;
        end
    end

endmodule

// File: rtl/tkp_ref_tracker.sv
module tkp_ref_tracker #(
    parameter int CNT_W  = 16,
    parameter int UP_CYC = 30,
    parameter int DN_CYC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             load,
    input  logic             track_en,
    input  logic [CNT_W-1:0] raw,
    output logic [CNT_W-1:0] ref_q
);

    localparam int UW = $clog2(UP_CYC + 1);
    localparam int DW = $clog2(DN_CYC + 1);
    localparam logic [UW-1:0] UP_LAST = UW'(UP_CYC - 1);
    localparam logic [DW-1:0] DN_LAST = DW'(DN_CYC - 1);

    logic [UW-1:0] up_cnt;
    logic [DW-1:0] dn_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q  <= '0;
            up_cnt <= '0;
            dn_cnt <= '0;
        end else if (sample) begin
            if (load) begin
                ref_q  <= raw;
                up_cnt <= '0;
                dn_cnt <= '0;
            end else if (!track_en) begin
                up_cnt <= '0;
                dn_cnt <= '0;
            end else if (raw > ref_q) begin
                dn_cnt <= '0;
                if (up_cnt == UP_LAST) begin
                    up_cnt <= '0;
                    ref_q  <= ref_q + 1'b1;
                end else begin
                    up_cnt <= up_cnt + 1'b1;
                end
            end else if (raw < ref_q) begin
                up_cnt <= '0;
                if (dn_cnt == DN_LAST) begin
                    dn_cnt <= '0;
                    ref_q  <= ref_q - 1'b1;
                end else begin
                    dn_cnt <= dn_cnt + 1'b1;
                end
            end else begin
                up_cnt <= '0;
                dn_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/tkp_ontimer.sv
module tkp_ontimer
    import tkp_pkg::*;
#(
    parameter int SHORT_CYC = 303,
    parameter int LONG_CYC  = 1818
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sample,
    input  logic      run,
    input  out_mode_t mode,
    output logic      expire
);

    localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    logic [TW-1:0] cnt;
    logic [TW-1:0] lim;
    logic          lim_en;

    always_comb begin
        lim    = TW'(SHORT_CYC);
        lim_en = 1'b1;
        unique case (mode)
            MD_DIRECT_INF:   lim_en = 1'b0;
            MD_DIRECT_SHORT: lim    = TW'(SHORT_CYC);
            MD_DIRECT_LONG:  lim    = TW'(LONG_CYC);
            MD_TOGGLE:       lim    = TW'(SHORT_CYC);
        endcase
    end

    assign expire = sample && run && lim_en && (cnt == lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (sample && (cnt != {TW{1'b1}})) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tkp_detect_fsm.sv
module tkp_detect_fsm
    import tkp_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int THRESH  = 6,
    parameter int HYST    = 2,
    parameter int CONFIRM = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [CNT_W-1:0] raw,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             arb_block,
    input  out_mode_t        mode,
    input  logic             expire,
    output det_state_t       state_q,
    output logic             load_ref,
    output logic             track_en,
    output logic             key_on
);

    localparam int IW = $clog2(CONFIRM + 1);
    localparam logic [IW-1:0] INT_LAST = IW'(CONFIRM - 1);
    localparam logic [CNT_W:0] ON_OFS  = (CNT_W+1)'(THRESH);
    localparam logic [CNT_W:0] OFF_OFS = (CNT_W+1)'(THRESH - HYST);

    det_state_t    state_n;
    logic [IW-1:0] integ_q, integ_n;
    logic          tog_q, tog_n;
    logic          cand, hold;

    // Comparisons carried one bit wider so ref near full scale cannot wrap
    assign cand = {1'b0, raw} >= ({1'b0, ref_val} + ON_OFS);
    assign hold = {1'b0, raw} >= ({1'b0, ref_val} + OFF_OFS);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CAL;
            integ_q <= '0;
            tog_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            integ_q <= integ_n;
            tog_q   <= tog_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        integ_n = integ_q;
        tog_n   = (mode == MD_TOGGLE) ? tog_q : 1'b0;
        if (sample) begin
            unique case (state_q)
                ST_CAL: begin
                    state_n = ST_IDLE;
                    integ_n = '0;
                end
                ST_IDLE: begin
                    if (cand) begin
                        state_n = ST_FILTER;
                        integ_n = IW'(1);
                    end
                end
                ST_FILTER: begin
                    if (!cand) begin
                        state_n = ST_IDLE;
                        integ_n = '0;
                    end else if (integ_q == INT_LAST) begin
                        integ_n = '0;
                        if (arb_block) begin
                            state_n = ST_SUPPR;
                        end else begin
                            state_n = ST_DETECT;
                            tog_n   = (mode == MD_TOGGLE) ? ~tog_q : 1'b0;
                        end
                    end else begin
                        integ_n = integ_q + 1'b1;
                    end
                end
                ST_SUPPR: begin
                    if (!cand) begin
                        state_n = ST_IDLE;
                    end else if (!arb_block) begin
                        state_n = ST_DETECT;
                        tog_n   = (mode == MD_TOGGLE) ? ~tog_q : 1'b0;
                    end
                end
                ST_DETECT: begin
                    if (!hold) begin
                        state_n = ST_IDLE;
                    end else if (expire) begin
                        state_n = ST_CAL;
                    end
                end
                default: state_n = ST_CAL;
            endcase
        end
    end

    // Outputs
    always_comb begin
        load_ref = (state_q == ST_CAL);
        track_en = (state_q == ST_IDLE) || (state_q == ST_FILTER);
        key_on   = (mode == MD_TOGGLE) ? tog_q : (state_q == ST_DETECT);
    end

endmodule

// File: rtl/touch_key_proc.sv
module touch_key_proc
    import tkp_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int ACQ_PERIOD_US = 33000,
    parameter int THRESH        = 6,
    parameter int HYST          = 2,
    parameter int CONFIRM       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_valid,
    input  logic [CNT_W-1:0] raw_count,
    input  logic             strap_opt_a,
    input  logic             strap_opt_b,
    input  logic             strap_oc,
    input  logic             arb_block,
    output logic             key_on,
    output logic             pad_o,
    output logic             pad_oe
);

    localparam int DRIFT_UP_CYC  = 990000 / ACQ_PERIOD_US;
    localparam int DRIFT_DN_CYC  = 231000 / ACQ_PERIOD_US;
    localparam int TMO_SHORT_CYC = 10000000 / ACQ_PERIOD_US;
    localparam int TMO_LONG_CYC  = 60000000 / ACQ_PERIOD_US;

    out_mode_t        mode_q;
    logic             oc_q;
    logic [CNT_W-1:0] ref_val;
    det_state_t       fsm_state;
    logic             load_ref, track_en, expire;

    tkp_strap_latch u_straps (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (raw_valid),
        .opt_a  (strap_opt_a),
        .opt_b  (strap_opt_b),
        .oc_in  (strap_oc),
        .mode_q (mode_q),
        .oc_q   (oc_q)
    );

    tkp_ref_tracker #(
        .CNT_W  (CNT_W),
        .UP_CYC (DRIFT_UP_CYC),
        .DN_CYC (DRIFT_DN_CYC)
    ) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (raw_valid),
        .load     (load_ref),
        .track_en (track_en),
        .raw      (raw_count),
        .ref_q    (ref_val)
    );

    tkp_ontimer #(
        .SHORT_CYC (TMO_SHORT_CYC),
        .LONG_CYC  (TMO_LONG_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (raw_valid),
        .run    (fsm_state == ST_DETECT),
        .mode   (mode_q),
        .expire (expire)
    );

    tkp_detect_fsm #(
        .CNT_W   (CNT_W),
        .THRESH  (THRESH),
        .HYST    (HYST),
        .CONFIRM (CONFIRM)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (raw_valid),
        .raw       (raw_count),
        .ref_val   (ref_val),
        .arb_block (arb_block),
        .mode      (mode_q),
        .expire    (expire),
        .state_q   (fsm_state),
        .load_ref  (load_ref),
        .track_en  (track_en),
        .key_on    (key_on)
    );

    // Pad stage: push-pull active-high, or open-drain active-low as enable
    always_comb begin
        if (oc_q) begin
            pad_o  = 1'b0;
            pad_oe = key_on;
        end else begin
            pad_o  = key_on;
            pad_oe = 1'b1;
        end
    end

endmodule

// File: rtl/tkp_checker.sv
module tkp_checker
    import tkp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             raw_valid,
    input logic             key_on,
    input logic             pad_o,
    input logic             oc_q,
    input det_state_t       state,
    input logic [CNT_W-1:0] ref_q
);

    AST_KEY_STABLE_BETWEEN_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_valid |=> $stable(key_on)); // R3

    AST_RISE_ONLY_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_on) |-> $past(raw_valid)); // R3

    AST_REF_FROZEN_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DETECT || state == ST_SUPPR) |=> $stable(ref_q)); // R7

    AST_REF_SLEW_ONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_FILTER) |=>
            (ref_q == $past(ref_q) || ref_q == $past(ref_q) + 1'b1 || ref_q == $past(ref_q) - 1'b1)); // R5

    AST_OPEN_DRAIN_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        oc_q |-> !pad_o); // R13

endmodule

bind touch_key_proc tkp_checker #(.CNT_W(CNT_W)) u_tkp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_valid (raw_valid),
    .key_on    (key_on),
    .pad_o     (pad_o),
    .oc_q      (oc_q),
    .state     (fsm_state),
    .ref_q     (ref_val)
);

// File: tb/touch_key_proc_bench.sv
`timescale 1ns/1ps
module touch_key_proc_bench;

    localparam int BASE = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raw_valid = 1'b0;
    logic [15:0] raw_count = '0;
    logic        strap_opt_a = 1'b0;
    logic        strap_opt_b = 1'b0;
    logic        strap_oc = 1'b0;
    logic        arb_block = 1'b0;
    logic        key_on, pad_o, pad_oe;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    touch_key_proc u_touch_key_proc (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_valid   (raw_valid),
        .raw_count   (raw_count),
        .strap_opt_a (strap_opt_a),
        .strap_opt_b (strap_opt_b),
        .strap_oc    (strap_oc),
        .arb_block   (arb_block),
        .key_on      (key_on),
        .pad_o       (pad_o),
        .pad_oe      (pad_oe)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic a, input logic b, input logic oc);
        @(negedge clk);
        rst_n       = 1'b0;
        raw_valid   = 1'b0;
        arb_block   = 1'b0;
        strap_opt_a = a;
        strap_opt_b = b;
        strap_oc    = oc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One valid sample; outputs are settled at the returning negedge
    task automatic send(input int v, input int n = 1);
        for (int i = 0; i < n; i++) begin
            raw_count = 16'(v);
            raw_valid = 1'b1;
            @(negedge clk);
            raw_valid = 1'b0;
        end
    endtask

    task automatic calib(input logic a, input logic b);
        do_reset(a, b, 1'b0);
        send(BASE);
    endtask

    task automatic t_reset;
        do_reset(1'b0, 1'b0, 1'b0);
        chk("R1", "key_on after reset", key_on, 1'b0);
        chk("R13", "pad_oe after reset", pad_oe, 1'b1);
        send(BASE + 50);
        send(BASE + 50, 3);
        chk("R1", "first sample loads reference", key_on, 1'b0);
        send(BASE + 60, 3);
        chk("R1", "detect before reset pulse", key_on, 1'b1);
        do_reset(1'b0, 1'b0, 1'b0);
        chk("R1", "reset pulse clears output", key_on, 1'b0);
        send(BASE + 60);
        send(BASE + 60, 3);
        chk("R1", "recalibrated after pulse", key_on, 1'b0);
    endtask

    task automatic t_threshold;
        calib(1'b0, 1'b0);
        send(BASE + 5, 3);
        chk("R2", "ref+5 is not candidate", key_on, 1'b0);
        send(BASE + 6, 3);
        chk("R2", "ref+6 is candidate", key_on, 1'b1);
    endtask

    task automatic t_consensus;
        calib(1'b0, 1'b0);
        send(BASE + 10, 2);
        chk("R3", "two candidates not enough", key_on, 1'b0);
        send(BASE);
        send(BASE + 10, 2);
        chk("R3", "count restarts after miss", key_on, 1'b0);
        send(BASE + 10);
        chk("R3", "third consecutive confirms", key_on, 1'b1);
    endtask

    task automatic t_hysteresis;
        calib(1'b0, 1'b0);
        send(BASE + 10, 3);
        send(BASE + 4);
        chk("R4", "ref+4 keeps detection", key_on, 1'b1);
        send(BASE + 3);
        chk("R4", "ref+3 releases", key_on, 1'b0);
    endtask

    task automatic t_drift_up;
        calib(1'b0, 1'b0);
        send(BASE + 2, 30);
        send(BASE + 6, 3);
        chk("R5", "reference rose by one", key_on, 1'b0);
        send(BASE + 7, 3);
        chk("R5", "reference rose by exactly one", key_on, 1'b1);
    endtask

    task automatic t_drift_down;
        calib(1'b0, 1'b0);
        send(BASE - 3, 6);
        send(BASE + 5, 3);
        chk("R6", "six low samples no step", key_on, 1'b0);
        calib(1'b0, 1'b0);
        send(BASE - 3, 7);
        send(BASE + 5, 3);
        chk("R6", "seven low samples step down", key_on, 1'b1);
    endtask

    task automatic t_freeze;
        calib(1'b0, 1'b0);
        send(BASE + 20, 43);
        chk("R7", "held detection", key_on, 1'b1);
        send(BASE + 3);
        chk("R7", "released", key_on, 1'b0);
        send(BASE + 6, 3);
        chk("R7", "reference frozen while detected", key_on, 1'b1);
    endtask

    task automatic t_suppress;
        calib(1'b0, 1'b0);
        arb_block = 1'b1;
        send(BASE + 20, 3);
        chk("R8", "blocked key stays off", key_on, 1'b0);
        send(BASE + 20, 40);
        chk("R8", "blocked key stays off long", key_on, 1'b0);
        arb_block = 1'b0;
        send(BASE + 20);
        chk("R8", "unblock activates at once", key_on, 1'b1);
        arb_block = 1'b1;
        send(BASE + 20);
        chk("R8", "block ignored once detected", key_on, 1'b1);
        arb_block = 1'b0;
        send(BASE + 3);
        send(BASE + 6, 3);
        chk("R7", "reference frozen while suppressed", key_on, 1'b1);
    endtask

    task automatic t_timeout_short;
        calib(1'b1, 1'b1);
        send(BASE + 20, 3);
        send(BASE + 20, 302);
        chk("R9", "on before 303rd sample", key_on, 1'b1);
        send(BASE + 20);
        chk("R9", "drops at 303rd sample", key_on, 1'b0);
        send(BASE + 20);
        send(BASE + 20, 3);
        chk("R9", "recalibrated to touched level", key_on, 1'b0);
        send(BASE + 26, 3);
        chk("R9", "new reference exact", key_on, 1'b1);
    endtask

    task automatic t_timeout_long;
        calib(1'b1, 1'b0);
        send(BASE + 20, 3);
        send(BASE + 20, 1817);
        chk("R10", "on before 1818th sample", key_on, 1'b1);
        send(BASE + 20);
        chk("R10", "drops at 1818th sample", key_on, 1'b0);
        calib(1'b0, 1'b0);
        send(BASE + 20, 2003);
        chk("R10", "no timeout in infinite mode", key_on, 1'b1);
    endtask

    task automatic t_toggle;
        calib(1'b0, 1'b1);
        send(BASE + 20, 3);
        chk("R11", "first touch turns on", key_on, 1'b1);
        send(BASE);
        chk("R11", "release keeps state", key_on, 1'b1);
        send(BASE + 20, 3);
        chk("R11", "second touch turns off", key_on, 1'b0);
        send(BASE);
        send(BASE + 20, 3);
        send(BASE + 20, 302);
        chk("R11", "on before timeout", key_on, 1'b1);
        send(BASE + 20);
        chk("R11", "timeout keeps output", key_on, 1'b1);
        send(BASE + 20);
        send(BASE + 26, 3);
        chk("R11", "recalibrated then toggles off", key_on, 1'b0);
    endtask

    task automatic t_polarity;
        calib(1'b0, 1'b0);
        chk("R13", "push-pull idle level", pad_o, 1'b0);
        send(BASE + 20, 3);
        chk("R13", "push-pull active high", pad_o, 1'b1);
        chk("R13", "push-pull enabled", pad_oe, 1'b1);
        strap_oc = 1'b1;
        @(negedge clk);
        chk("R12", "strap change waits for sample", pad_o, 1'b1);
        send(BASE + 20);
        chk("R13", "open-drain pulls low", pad_o, 1'b0);
        chk("R13", "open-drain enabled when on", pad_oe, 1'b1);
        send(BASE);
        chk("R13", "open-drain released when off", pad_oe, 1'b0);
        strap_opt_a = 1'b1;
        strap_opt_b = 1'b1;
        send(BASE + 20, 3);
        send(BASE + 20, 302);
        send(BASE + 20);
        chk("R12", "strap resampled at runtime", key_on, 1'b0);
    endtask

    initial begin
        t_reset();
        t_threshold();
        t_consensus();
        t_hysteresis();
        t_drift_up();
        t_drift_down();
        t_freeze();
        t_suppress();
        t_timeout_short();
        t_timeout_long();
        t_toggle();
        t_polarity();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule